// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes (19 address lines, 8 data lines, active-low chip select, write strobe and output strobe). The host raises a request together with an address, a write flag and write data while the ready flag is high. The sequencer then holds the address and runs the strobe phases that the RAM's timing limits call for. A read ends with a one-cycle valid pulse that carries the sampled byte.

Every timing limit is a nanosecond-scale parameter given in picoseconds. It is converted to a whole number of system clock cycles, so the same RTL serves any clock and any speed grade. The data pins are split into an output value, an output enable and an input value, and the pad tri-state sits outside the block. Between accesses the RAM is held deselected, which is its standby state, and the bus is left floating.

Top module: `asram_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release: ready_o=1, rvalid_o=0, sram_ce_no=sram_we_no=sram_oe_no=1 and sram_dq_oe_o=0.
- R2: Whenever the block is idle (ready_o=1), sram_ce_no=1 and sram_dq_oe_o=0. After an access ends, ready_o returns to 1 in the cycle that follows the last strobe phase.
- R3: A write (wr_i=1 on an accepted request) drives sram_we_no low for exactly NPW cycles. NPW is the larger of the cycle counts for the write pulse width and for the data setup time. sram_ce_no is low and sram_oe_no is high throughout.
- R4: sram_addr_o equals the accepted address for as long as sram_ce_no is low. A write keeps sram_we_no high for NAS cycles (the address setup count) after chip select falls, and it raises sram_we_no before the address can change.
- R5: During a write, sram_dq_oe_o is 1 and sram_dq_o holds the accepted data in every cycle in which sram_ce_no is low. Chip select stays low for NAS+NPW+NREC cycles. NREC is the write-recovery count, lengthened as needed so that the total is at least the write-cycle count.
- R6: A read (wr_i=0) holds sram_ce_no and sram_oe_no low and sram_we_no high for NACC cycles, with sram_dq_oe_o=0. NACC is the larger of the access-time and read-cycle counts.
- R7: The read byte is sampled from sram_dq_i at the clock edge that ends the last access cycle. It appears on rdata_o with rvalid_o=1 for exactly one cycle, the cycle right after that edge.
- R8: After sram_oe_no rises at the end of a read, chip select and output strobe stay high and sram_dq_oe_o stays 0 for NOHZ cycles (the output-disable count). Only after that can the next access begin, so the host's drivers never overlap the RAM's.
- R9: ready_o is 0 from the cycle after acceptance until the access ends. A request raised while ready_o=0 is ignored: it starts no access and changes no memory location.
- R10: Each cycle count is the ceiling of the limit divided by CLK_PS, with a minimum of one. A zero-nanosecond setup or recovery limit therefore still costs one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, taken when ready_o=1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | One-cycle read completion pulse |
| sram_addr_o | output | 19 | RAM address lines |
| sram_dq_o | output | 8 | Value for the RAM data pins |
| sram_dq_oe_o | output | 1 | Drive enable for the RAM data pins |
| sram_dq_i | input | 8 | Value read from the RAM data pins |
| sram_ce_no | output | 1 | RAM chip select, active low |
| sram_we_no | output | 1 | RAM write strobe, active low |
| sram_oe_no | output | 1 | RAM output strobe, active low |

## Verification
A wrong phase state or a miscounted phase timer shows at the strobe pins in the very cycle it happens. The bench traces every cycle of every access against the phase lengths it derives itself, so a single cycle of extra or missing pulse width is caught at once. A read sampled too early returns a filler byte, because the RAM model drives real data only in the last access cycle, and rdata_o exposes this one cycle after the sample. An address or data register that fails to load shows up on the address lines during the access, or later as a wrong byte on read-back.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSU,
    ST_WPL,
    ST_WREC,
    ST_RACC,
    ST_RTRN
  } st_e;

  // ceil(t/clk), never below one cycle
  function automatic int unsigned ps2cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 32'd1) / clk_ps;
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (acc_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_AS_PS   = 0,
  parameter int unsigned T_WP_PS   = 8000,
  parameter int unsigned T_DW_PS   = 6000,
  parameter int unsigned T_WR_PS   = 0,
  parameter int unsigned T_WC_PS   = 10000,
  parameter int unsigned T_AA_PS   = 10000,
  parameter int unsigned T_RC_PS   = 10000,
  parameter int unsigned T_OHZ_PS  = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no
);
  localparam int unsigned NAS   = ps2cyc(T_AS_PS, CLK_PS);
  localparam int unsigned NPW   = umax(ps2cyc(T_WP_PS, CLK_PS), ps2cyc(T_DW_PS, CLK_PS));
  localparam int unsigned NWR   = ps2cyc(T_WR_PS, CLK_PS);
  localparam int unsigned NWC   = ps2cyc(T_WC_PS, CLK_PS);
  localparam int unsigned NREC  = (NWC > NAS + NPW + NWR) ? (NWC - NAS - NPW) : NWR;
  localparam int unsigned NACC  = umax(ps2cyc(T_AA_PS, CLK_PS), ps2cyc(T_RC_PS, CLK_PS));
  localparam int unsigned NOHZ  = ps2cyc(T_OHZ_PS, CLK_PS);
  localparam int unsigned NMAX  = umax(umax(umax(NAS, NPW), umax(NREC, NACC)), NOHZ);
  localparam int unsigned CNT_W = (NMAX > 1) ? $clog2(NMAX) : 1;

  st_e              st_q, st_d;
  logic             ld, done, acc, cap;
  logic [CNT_W-1:0] ld_val;

  asram_timer #(.W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (done)
  );

  asram_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cap_i    (cap),
    .dq_i     (sram_dq_i),
    .addr_o   (sram_addr_o),
    .wdata_o  (sram_dq_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    acc    = 1'b0;
    cap    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        acc = 1'b1;
        ld  = 1'b1;
        if (wr_i) begin
          st_d   = ST_WSU;
          ld_val = CNT_W'(NAS - 1);
        end else begin
          st_d   = ST_RACC;
          ld_val = CNT_W'(NACC - 1);
        end
      end
      ST_WSU: if (done) begin
        st_d   = ST_WPL;
        ld     = 1'b1;
        ld_val = CNT_W'(NPW - 1);
      end
      ST_WPL: if (done) begin
        st_d   = ST_WREC;
        ld     = 1'b1;
        ld_val = CNT_W'(NREC - 1);
      end
      ST_WREC: if (done) st_d = ST_IDLE;
      ST_RACC: if (done) begin
        cap    = 1'b1;
        st_d   = ST_RTRN;
        ld     = 1'b1;
        ld_val = CNT_W'(NOHZ - 1);
      end
      ST_RTRN: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o      = (st_q == ST_IDLE);
  assign sram_ce_no   = (st_q == ST_IDLE) || (st_q == ST_RTRN);
  assign sram_we_no   = (st_q != ST_WPL);
  assign sram_oe_no   = (st_q != ST_RACC);
  assign sram_dq_oe_o = (st_q == ST_WSU) || (st_q == ST_WPL) || (st_q == ST_WREC);

  p_ready_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && !sram_dq_oe_o));

  p_we_needs_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_oe_no && sram_dq_oe_o));

  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

  p_we_rise_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (!sram_ce_no && $stable(sram_addr_o)));

  p_rvalid_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!sram_oe_no));

  p_rvalid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_no_contention_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  p_turn_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |=> (!sram_dq_oe_o && sram_ce_no));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int unsigned CLK   = 10000;
  localparam int unsigned AS    = 5000;
  localparam int unsigned WP    = 25000;
  localparam int unsigned DWS   = 6000;
  localparam int unsigned WR    = 12000;
  localparam int unsigned WC    = 70000;
  localparam int unsigned AA    = 32000;
  localparam int unsigned RC    = 20000;
  localparam int unsigned OHZ   = 14000;

  // expected counts, R10: ceil with minimum one
  localparam int E_NAS  = 1;                       // 5000 -> 1
  localparam int E_NPW  = (WP + CLK - 1) / CLK;    // 3 (> data setup 1)
  localparam int E_NWR  = (WR + CLK - 1) / CLK;    // 2
  localparam int E_NWC  = (WC + CLK - 1) / CLK;    // 7
  localparam int E_NREC = (E_NWC - E_NAS - E_NPW > E_NWR) ? E_NWC - E_NAS - E_NPW : E_NWR; // 3
  localparam int E_NACC = (AA + CLK - 1) / CLK;    // 4 (> read cycle 2)
  localparam int E_NOHZ = (OHZ + CLK - 1) / CLK;   // 2
  localparam int E_WTOT = E_NAS + E_NPW + E_NREC;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [18:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o, sram_dq_oe_o, sram_ce_no, sram_we_no, sram_oe_no;
  logic [7:0]  rdata_o, sram_dq_o, sram_dq_i;
  logic [18:0] sram_addr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5ns clk_i = ~clk_i;

  asram_ctrl #(
    .CLK_PS(CLK), .T_AS_PS(AS), .T_WP_PS(WP), .T_DW_PS(DWS), .T_WR_PS(WR),
    .T_WC_PS(WC), .T_AA_PS(AA), .T_RC_PS(RC), .T_OHZ_PS(OHZ)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .sram_addr_o(sram_addr_o), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i(sram_dq_i), .sram_ce_no(sram_ce_no), .sram_we_no(sram_we_no),
    .sram_oe_no(sram_oe_no)
  );

  // RAM model: 64 locations on addr[5:0]; real data only in the final access cycle
  logic [7:0] mem [0:63];
  int oe_cnt = 0;
  always @(posedge clk_i) oe_cnt <= sram_oe_no ? 0 : oe_cnt + 1;
  always @(posedge sram_we_no) if (sram_ce_no === 1'b0) mem[sram_addr_o[5:0]] <= sram_dq_o;
  assign sram_dq_i = (!sram_ce_no && !sram_oe_no && sram_we_no && oe_cnt >= E_NACC - 1)
                     ? mem[sram_addr_o[5:0]] : 8'h5a;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // R8 monitor: cycles between OE# rising and the next drive enable
  int since_rd = 1000;
  logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
  always @(negedge clk_i) begin
    if (!prev_oe_n && sram_oe_no) since_rd = 1;
    else if (since_rd < 1000) since_rd++;
    if (sram_dq_oe_o && !prev_dq_oe && since_rd < 1000)
      chk("R8 turnaround gap", 32'(since_rd > E_NOHZ + 1), 32'd1);
    prev_oe_n  = sram_oe_no;
    prev_dq_oe = sram_dq_oe_o;
  end

  function automatic logic [18:0] map_addr(input int a);
    return {a[5:0], 7'h00, a[5:0]};
  endfunction

  // called at a negedge with the block idle
  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    chk("R2 ready before write", 32'(ready_o), 32'd1);
    req_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    for (int k = 1; k <= E_WTOT + 1; k++) begin
      @(negedge clk_i);
      if (k == 1) begin req_i = 1'b0; addr_i = ~a; wdata_i = ~d; end
      if (k <= E_WTOT) begin
        chk("R3 strobes ce/we/oe", {29'd0, sram_ce_no, sram_we_no, sram_oe_no},
            {29'd0, 1'b0, !(k > E_NAS && k <= E_NAS + E_NPW), 1'b1});
        chk("R4 address hold", 32'(sram_addr_o), 32'(a));
        chk("R5 data drive", {23'd0, sram_dq_oe_o, sram_dq_o}, {23'd0, 1'b1, d});
        chk("R9 busy", 32'(ready_o), 32'd0);
      end else begin
        chk("R2 idle standby", {30'd0, ready_o, sram_ce_no}, 32'd3);
        chk("R5 drive released", 32'(sram_dq_oe_o), 32'd0);
      end
    end
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] d, input bit poke,
                         input logic [18:0] pa);
    chk("R2 ready before read", 32'(ready_o), 32'd1);
    req_i = 1'b1; wr_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    for (int k = 1; k <= E_NACC + E_NOHZ + 1; k++) begin
      @(negedge clk_i);
      if (k == 1) req_i = 1'b0;
      if (poke && k == 2) begin req_i = 1'b1; wr_i = 1'b1; addr_i = pa; wdata_i = 8'hc3; end
      if (poke && k == E_NACC + E_NOHZ) req_i = 1'b0;
      if (k <= E_NACC) begin
        chk("R6 strobes ce/we/oe", {29'd0, sram_ce_no, sram_we_no, sram_oe_no}, 32'b010);
        chk("R6 no drive", 32'(sram_dq_oe_o), 32'd0);
        chk("R4 address hold", 32'(sram_addr_o), 32'(a));
        chk("R7 no early valid", 32'(rvalid_o), 32'd0);
      end else if (k <= E_NACC + E_NOHZ) begin
        chk("R8 turnaround idle pins", {28'd0, sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o},
            32'b1110);
        chk("R9 busy", 32'(ready_o), 32'd0);
        chk("R7 valid pulse", 32'(rvalid_o), 32'(k == E_NACC + 1));
        if (k == E_NACC + 1) chk("R7 read data", 32'(rdata_o), 32'(d));
      end else begin
        chk("R2 idle standby", {30'd0, ready_o, sram_ce_no}, 32'd3);
        chk("R9 ignored request started nothing", 32'(sram_dq_oe_o), 32'd0);
      end
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + 5 + s * 91) & 255);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {26'd0, ready_o, rvalid_o, sram_ce_no, sram_we_no, sram_oe_no,
        sram_dq_oe_o}, 32'b101110);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {26'd0, ready_o, rvalid_o, sram_ce_no, sram_we_no, sram_oe_no,
        sram_dq_oe_o}, 32'b101110);
    chk("R10 pulse covers setup", 32'(E_NPW), 32'd3);

    for (int a = 0; a < 64; a++) do_write(map_addr(a), pat(a, 0));
    for (int a = 0; a < 64; a++)
      do_read(map_addr(a), pat(a, 0), (a % 16) == 3, map_addr((a + 1) % 64));
    // read immediately followed by write, then read back
    for (int a = 0; a < 8; a++) begin
      do_read(map_addr(a), pat(a, 0), 1'b0, '0);
      do_write(map_addr(a), pat(a, 1));
      do_read(map_addr(a), pat(a, 1), 1'b0, '0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule